// File: doc/BRIEF.md
# Quad DAC Register Update Controller

This block is the digital front end of a four-channel, 16-bit voltage-output converter. A host sends 32-bit command words over a three-wire serial link: an active-low frame select, a serial clock and a data line. Each channel has two registers. The input register holds a staged code. The DAC register holds the code that reaches the converter, and the block drives the four DAC register values as its outputs. Besides the per-channel registers, the block keeps a 2-bit clear code and a 4-bit per-channel load mask.

Two pins act outside the serial stream. The active-low clear pin, on its falling edge, forces every input and DAC register to a programmable preset. It also discards any frame being shifted in at that moment, and it raises a clear-mode flag that stays up until the next write completes. The active-low load pin, on its falling edge, copies input registers into DAC registers. While it is held low, the copy happens at the end of every accepted frame. Channels whose mask bit is set ignore the load pin entirely: their DAC register follows each write to their input register at once.

All serial and pin inputs are sampled in the block's own core clock domain. They pass through a synchronizer and are edge-detected there, so the serial clock must be several times slower than the core clock.

Top module: `dacfe_top`

## Requirements
- R1: After reset every DAC output is 0x0000, the clear code selects zero scale, all mask bits are 0, and the clear-mode flag is low.
- R2: A frame starts when `sync_n` falls. Bits are taken MSB first on falling `sclk` edges. The frame is acted on at the 32nd falling edge, with the command in bits 27:24, the address in bits 23:20 and the data in bits 19:4. Bits 31:28 and 3:0 are ignored. A frame whose `sync_n` rises before the 32nd falling edge has no effect.
- R3: Command 0000 writes the data into the input register of the addressed channel. Address 0 to 3 selects one channel, address 1111 selects all four, and any other address selects none. With the mask bit clear and `ldac_n` high, the DAC outputs do not change.
- R4: Command 0001 copies the input register of the addressed channel, or of all four channels for address 1111, into its DAC register.
- R5: Command 0011 writes the input register of the addressed channel and then copies all four input registers into their DAC registers.
- R6: Command 0101 loads the clear code from data bits 1:0. The codes are 00 for 0x0000, 01 for 0x8000, 10 for 0xFFFF, and 11 for "clear disabled".
- R7: When the clear code is not 11, a falling edge on `clr_n` sets every input register and every DAC register to the preset value and raises `clr_mode`.
- R8: When the clear code is 11, a falling edge on `clr_n` changes no register and does not touch `clr_mode`.
- R9: A clear event (R7) during a frame discards that frame, including any remaining clock edges, until `sync_n` falls again.
- R10: `clr_mode` falls at the end of the next frame that completes with command 0000, 0001, 0011, 0101 or 0110. It rises only on a clear event.
- R11: Command 0110 loads the load mask from data bits 3:0, one bit per channel. A channel whose mask bit is 1 gets its DAC register written together with its input register, and it ignores `ldac_n`.
- R12: A falling edge on `ldac_n` copies the input register into the DAC register for every channel whose mask bit is 0.
- R13: While `ldac_n` is low, each completed frame with a defined command ends with the input registers copied into the DAC registers of all channels whose mask bit is 0.
- R14: Any other command code leaves every register and `clr_mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| clr_n | input | 1 | Active-low clear; acts on its falling edge |
| ldac_n | input | 1 | Active-low load; edge copies, low level makes frames copy |
| dac_out | output | 64 | Four DAC register values, channel 0 in bits 15:0 |
| clr_mode | output | 1 | High from a clear event until the next completed write |

## Verification
Single-channel writes, broadcast writes and write-and-update-all frames are sent with distinct data patterns, so the bench can tell a wrong address decode from a wrong update scope. Each input register is observed through a later update command or a load pulse. A frame cut short by `sync_n` and a frame cut by a clear pulse in its middle tell discarding apart from late completion. All four clear codes are applied, and the disabled code shows that input registers keep their contents. Mask patterns that split the channels, together with load pulses and a load pin held low, separate immediate update from pin-driven update.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int NCH        = 4;
    localparam int DATA_W     = 16;
    localparam int CMD_W      = 4;
    localparam int ADDR_W     = 4;
    localparam int FRAME_BITS = 32;
    localparam int FLD_LSB    = 4;
    localparam int FLD_W      = CMD_W + ADDR_W + DATA_W;
    localparam int SR_W       = FLD_LSB + FLD_W;
    localparam int CODE_W     = 2;

    localparam logic [CMD_W-1:0]  CMD_WR_IN      = 4'b0000;
    localparam logic [CMD_W-1:0]  CMD_UPD_ONE    = 4'b0001;
    localparam logic [CMD_W-1:0]  CMD_WR_UPD_ALL = 4'b0011;
    localparam logic [CMD_W-1:0]  CMD_SET_CLR    = 4'b0101;
    localparam logic [CMD_W-1:0]  CMD_SET_MASK   = 4'b0110;
    localparam logic [ADDR_W-1:0] ADDR_ALL       = 4'b1111;

    localparam logic [CODE_W-1:0] CLR_ZERO = 2'b00;
    localparam logic [CODE_W-1:0] CLR_MID  = 2'b01;
    localparam logic [CODE_W-1:0] CLR_FULL = 2'b10;
    localparam logic [CODE_W-1:0] CLR_OFF  = 2'b11;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic [DATA_W-1:0] clr_value(input logic [CODE_W-1:0] code);
        logic [DATA_W-1:0] v;
        case (code)
            CLR_MID:  v = {1'b1, {(DATA_W-1){1'b0}}};
            CLR_FULL: v = {DATA_W{1'b1}};
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift
    import dacfe_pkg::*;
#(
    parameter int FB = FRAME_BITS
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sync_fall,
    input  logic   sync_lvl_n,
    input  logic   sclk_fall,
    input  logic   din,
    input  logic   abort,
    output logic   frame_done,
    output frame_t frame_o,
    output logic   busy
);

    localparam int CNTW = $clog2(FB);

    typedef struct packed {
        logic            armed;
        logic [CNTW-1:0] cnt;
        logic [SR_W-1:0] sr;
        logic            done;
    } shift_st_t;

    shift_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        if (abort) begin
            nxt_d.armed = 1'b0;
            nxt_d.cnt   = '0;
        end else if (sync_fall) begin
            nxt_d.armed = 1'b1;
            nxt_d.cnt   = '0;
        end else if (sync_lvl_n) begin
            nxt_d.armed = 1'b0;
            nxt_d.cnt   = '0;
        end else if (cur_q.armed && sclk_fall) begin
            nxt_d.sr = {cur_q.sr[SR_W-2:0], din};
            if (cur_q.cnt == CNTW'(FB-1)) begin
                nxt_d.done  = 1'b1;
                nxt_d.armed = 1'b0;
                nxt_d.cnt   = '0;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign frame_done = cur_q.done;
    assign frame_o    = frame_t'(cur_q.sr[FLD_LSB +: FLD_W]);
    assign busy       = cur_q.armed;

endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
    import dacfe_pkg::*;
#(
    parameter int N  = NCH,
    parameter int DW = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  frame_t               frm,
    input  logic                 clr_take,
    input  logic                 ldac_fall,
    input  logic                 ldac_lvl_n,
    output logic [N-1:0][DW-1:0] dac_o,
    output logic [CODE_W-1:0]    clr_code_o,
    output logic [N-1:0]         mask_o,
    output logic                 clr_mode_o
);

    typedef struct packed {
        logic [N-1:0][DW-1:0] inr;
        logic [N-1:0][DW-1:0] dac;
        logic [CODE_W-1:0]    code;
        logic [N-1:0]         mask;
        logic                 clr_mode;
    } reg_st_t;

    reg_st_t      cur_q, nxt_d;
    logic [N-1:0] sel;
    logic         cmd_known;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            sel[i] = (frm.addr == ADDR_ALL) || (frm.addr == ADDR_W'(i));
        end
    end

    always_comb begin
        nxt_d     = cur_q;
        cmd_known = 1'b0;
        if (clr_take) begin
            for (int i = 0; i < N; i++) begin
                nxt_d.inr[i] = clr_value(cur_q.code);
                nxt_d.dac[i] = clr_value(cur_q.code);
            end
            nxt_d.clr_mode = 1'b1;
        end else begin
            if (frame_done) begin
                case (frm.cmd)
                    CMD_WR_IN: begin
                        cmd_known = 1'b1;
                        for (int i = 0; i < N; i++) begin
                            if (sel[i]) begin
                                nxt_d.inr[i] = frm.data;
                                if (cur_q.mask[i]) nxt_d.dac[i] = frm.data;
                            end
                        end
                    end
                    CMD_UPD_ONE: begin
                        cmd_known = 1'b1;
                        for (int i = 0; i < N; i++) begin
                            if (sel[i]) nxt_d.dac[i] = cur_q.inr[i];
                        end
                    end
                    CMD_WR_UPD_ALL: begin
                        cmd_known = 1'b1;
                        for (int i = 0; i < N; i++) begin
                            if (sel[i]) nxt_d.inr[i] = frm.data;
                            nxt_d.dac[i] = nxt_d.inr[i];
                        end
                    end
                    CMD_SET_CLR: begin
                        cmd_known  = 1'b1;
                        nxt_d.code = frm.data[CODE_W-1:0];
                    end
                    CMD_SET_MASK: begin
                        cmd_known  = 1'b1;
                        nxt_d.mask = frm.data[N-1:0];
                    end
                    default: cmd_known = 1'b0;
                endcase
                if (cmd_known) begin
                    nxt_d.clr_mode = 1'b0;
                    if (!ldac_lvl_n) begin
                        for (int i = 0; i < N; i++) begin
                            if (!nxt_d.mask[i]) nxt_d.dac[i] = nxt_d.inr[i];
                        end
                    end
                end
            end
            if (ldac_fall) begin
                for (int i = 0; i < N; i++) begin
                    if (!nxt_d.mask[i]) nxt_d.dac[i] = nxt_d.inr[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dac_o      = cur_q.dac;
    assign clr_code_o = cur_q.code;
    assign mask_o     = cur_q.mask;
    assign clr_mode_o = cur_q.clr_mode;

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
    import dacfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int N           = NCH,
    parameter int DW          = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_n,
    input  logic          sclk,
    input  logic          sdin,
    input  logic          clr_n,
    input  logic          ldac_n,
    output logic [N*DW-1:0] dac_out,
    output logic          clr_mode
);

    localparam int PIN_W = 5;
    localparam int EDG_W = 4;

    logic [PIN_W-1:0] pin_lvl;
    logic             sync_lvl, sclk_lvl, din_lvl, clr_lvl, ldac_lvl;

    dacfe_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b11011)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sync_n, sclk, sdin, clr_n, ldac_n}),
        .sync_o  (pin_lvl)
    );

    assign {sync_lvl, sclk_lvl, din_lvl, clr_lvl, ldac_lvl} = pin_lvl;

    logic [EDG_W-1:0] prev_d, prev_q, cur_lvl, fall;
    logic             sync_fall, sclk_fall, clr_fall, ldac_fall;

    always_comb begin
        cur_lvl = {sync_lvl, sclk_lvl, clr_lvl, ldac_lvl};
        prev_d  = cur_lvl;
        fall    = prev_q & ~cur_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign {sync_fall, sclk_fall, clr_fall, ldac_fall} = fall;

    logic                 frame_done, busy, clr_take;
    frame_t               frm;
    logic [CODE_W-1:0]    clr_code;
    logic [N-1:0]         mask;
    logic [N-1:0][DW-1:0] dac_w;

    assign clr_take = clr_fall && (clr_code != CLR_OFF);

    dacfe_shift #(
        .FB (FRAME_BITS)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_fall  (sync_fall),
        .sync_lvl_n (sync_lvl),
        .sclk_fall  (sclk_fall),
        .din        (din_lvl),
        .abort      (clr_take),
        .frame_done (frame_done),
        .frame_o    (frm),
        .busy       (busy)
    );

    dacfe_regs #(
        .N  (N),
        .DW (DW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frm        (frm),
        .clr_take   (clr_take),
        .ldac_fall  (ldac_fall),
        .ldac_lvl_n (ldac_lvl),
        .dac_o      (dac_w),
        .clr_code_o (clr_code),
        .mask_o     (mask),
        .clr_mode_o (clr_mode)
    );

    for (genvar g = 0; g < N; g++) begin : g_out
        assign dac_out[g*DW +: DW] = dac_w[g];
    end

endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk
    import dacfe_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clr_take,
    input logic                   clr_fall,
    input logic [CODE_W-1:0]      clr_code,
    input logic                   frame_done,
    input logic                   ldac_fall,
    input logic                   busy,
    input logic [NCH-1:0]         mask,
    input logic [NCH*DATA_W-1:0]  dac_out,
    input logic                   clr_mode
);

    assert_clear_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_take |=> (dac_out == {NCH{clr_value($past(clr_code))}}) && clr_mode);

    assert_clear_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fall && clr_code == CLR_OFF && !frame_done && !ldac_fall)
            |=> $stable(dac_out) && $stable(clr_mode));

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_take |=> !busy && !frame_done);

    assert_mode_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_mode) |-> $past(clr_take));

    assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !ldac_fall && !clr_take) |=> $stable(dac_out));

    for (genvar g = 0; g < NCH; g++) begin : g_mask
        assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (mask[g] && ldac_fall && !frame_done && !clr_take)
                |=> $stable(dac_out[g*DATA_W +: DATA_W]));
    end

endmodule

bind dacfe_top dacfe_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_take   (clr_take),
    .clr_fall   (clr_fall),
    .clr_code   (clr_code),
    .frame_done (frame_done),
    .ldac_fall  (ldac_fall),
    .busy       (busy),
    .mask       (mask),
    .dac_out    (dac_out),
    .clr_mode   (clr_mode)
);

// File: tb/tb_dacfe_top.sv
module tb_dacfe_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int SETTLE     = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdin = 1'b0;
    logic        clr_n = 1'b1;
    logic        ldac_n = 1'b1;
    logic [63:0] dac_out;
    logic        clr_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacfe_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_n   (sync_n),
        .sclk     (sclk),
        .sdin     (sdin),
        .clr_n    (clr_n),
        .ldac_n   (ldac_n),
        .dac_out  (dac_out),
        .clr_mode (clr_mode)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_dac(input string tag, input logic [15:0] e3, input logic [15:0] e2,
                           input logic [15:0] e1, input logic [15:0] e0);
        chk(tag, dac_out, {e3, e2, e1, e0});
    endtask

    function automatic logic [31:0] mkw(input logic [3:0] cmd, input logic [3:0] addr,
                                         input logic [15:0] data);
        return {4'hA, cmd, addr, data, 4'h5};
    endfunction

    task automatic send_bit(input logic b);
        sdin = b;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic send_partial(input logic [31:0] w, input int nbits);
        sync_n = 1'b0;
        wait_clk(HALF);
        for (int b = 31; b > 31 - nbits; b--) send_bit(w[b]);
        sclk = 1'b1;
        wait_clk(HALF);
        sync_n = 1'b1;
        wait_clk(SETTLE);
    endtask

    task automatic send_frame(input logic [31:0] w);
        send_partial(w, 32);
    endtask

    task automatic pulse_clr();
        clr_n = 1'b0;
        wait_clk(HALF);
        clr_n = 1'b1;
        wait_clk(SETTLE);
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0;
        wait_clk(HALF);
        ldac_n = 1'b1;
        wait_clk(SETTLE);
    endtask

    task automatic t_reset();
        chk("R1 dac after reset", dac_out, 64'h0);
        chk("R1 clr_mode after reset", {63'h0, clr_mode}, 64'h0);
    endtask

    task automatic t_write_update();
        send_frame(mkw(4'b0000, 4'd1, 16'h1234));
        chk_dac("R3 input write leaves dac", 16'h0, 16'h0, 16'h0, 16'h0);
        send_frame(mkw(4'b0001, 4'd1, 16'hDEAD));
        chk_dac("R4 R2 update one channel", 16'h0, 16'h0, 16'h1234, 16'h0);
    endtask

    task automatic t_broadcast_ldac();
        send_frame(mkw(4'b0000, 4'hF, 16'hA5A5));
        chk_dac("R3 broadcast input only", 16'h0, 16'h0, 16'h1234, 16'h0);
        pulse_ldac();
        chk_dac("R12 load edge copies all", 16'hA5A5, 16'hA5A5, 16'hA5A5, 16'hA5A5);
    endtask

    task automatic t_short_and_all();
        send_frame(mkw(4'b0000, 4'd0, 16'h1111));
        send_partial(mkw(4'b0011, 4'd2, 16'h2222), 20);
        chk_dac("R2 short frame ignored", 16'hA5A5, 16'hA5A5, 16'hA5A5, 16'hA5A5);
        send_frame(mkw(4'b0011, 4'd2, 16'h2222));
        chk_dac("R5 write and update all", 16'hA5A5, 16'h2222, 16'hA5A5, 16'h1111);
    endtask

    task automatic t_clear_codes();
        send_frame(mkw(4'b0101, 4'd0, 16'h0001));
        pulse_clr();
        chk_dac("R7 R6 midscale clear", 16'h8000, 16'h8000, 16'h8000, 16'h8000);
        chk("R7 clr_mode set", {63'h0, clr_mode}, 64'h1);
        send_frame(mkw(4'b0001, 4'hF, 16'h0));
        chk_dac("R7 inputs cleared too", 16'h8000, 16'h8000, 16'h8000, 16'h8000);
        chk("R10 clr_mode exit on write", {63'h0, clr_mode}, 64'h0);
        send_frame(mkw(4'b0101, 4'd0, 16'h0002));
        pulse_clr();
        chk_dac("R6 full-scale clear", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        send_frame(mkw(4'b0101, 4'd0, 16'h0000));
        pulse_clr();
        chk_dac("R6 zero-scale clear", 16'h0, 16'h0, 16'h0, 16'h0);
    endtask

    task automatic t_abort();
        logic [31:0] w;
        send_frame(mkw(4'b0101, 4'd0, 16'h0002));
        w = mkw(4'b0011, 4'd0, 16'h4444);
        sync_n = 1'b0;
        wait_clk(HALF);
        for (int b = 31; b > 15; b--) send_bit(w[b]);
        clr_n = 1'b0;
        wait_clk(HALF);
        clr_n = 1'b1;
        wait_clk(HALF);
        for (int b = 15; b >= 0; b--) send_bit(w[b]);
        sclk = 1'b1;
        wait_clk(HALF);
        sync_n = 1'b1;
        wait_clk(SETTLE);
        chk_dac("R9 frame aborted by clear", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        chk("R10 clr_mode held after abort", {63'h0, clr_mode}, 64'h1);
    endtask

    task automatic t_code_off();
        send_frame(mkw(4'b0101, 4'd0, 16'h0003));
        send_frame(mkw(4'b0000, 4'd2, 16'h2468));
        pulse_clr();
        chk_dac("R8 disabled clear no change", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        chk("R8 clr_mode untouched", {63'h0, clr_mode}, 64'h0);
        send_frame(mkw(4'b0001, 4'd2, 16'h0));
        chk_dac("R8 input kept", 16'hFFFF, 16'h2468, 16'hFFFF, 16'hFFFF);
    endtask

    task automatic t_reserved();
        send_frame(mkw(4'b0101, 4'd0, 16'h0000));
        pulse_clr();
        send_frame(mkw(4'b0111, 4'hF, 16'h5555));
        send_frame(mkw(4'b1111, 4'd0, 16'h9999));
        chk_dac("R14 reserved no dac change", 16'h0, 16'h0, 16'h0, 16'h0);
        chk("R14 reserved keeps clr_mode", {63'h0, clr_mode}, 64'h1);
        pulse_ldac();
        chk_dac("R14 reserved no input change", 16'h0, 16'h0, 16'h0, 16'h0);
    endtask

    task automatic t_mask();
        send_frame(mkw(4'b0110, 4'd0, 16'h0005));
        send_frame(mkw(4'b0000, 4'hF, 16'h3C3C));
        chk_dac("R11 masked channels follow write", 16'h0, 16'h3C3C, 16'h0, 16'h3C3C);
        pulse_ldac();
        chk_dac("R12 load edge unmasked only", 16'h3C3C, 16'h3C3C, 16'h3C3C, 16'h3C3C);
        send_frame(mkw(4'b0000, 4'hF, 16'h7777));
        chk_dac("R11 second masked write", 16'h3C3C, 16'h7777, 16'h3C3C, 16'h7777);
        send_frame(mkw(4'b0110, 4'd0, 16'h0000));
        pulse_ldac();
        chk_dac("R12 load after mask cleared", 16'h7777, 16'h7777, 16'h7777, 16'h7777);
    endtask

    task automatic t_sync_load();
        ldac_n = 1'b0;
        wait_clk(SETTLE);
        send_frame(mkw(4'b0000, 4'd3, 16'h0F0F));
        chk_dac("R13 held load updates at frame", 16'h0F0F, 16'h7777, 16'h7777, 16'h7777);
        send_frame(mkw(4'b0000, 4'd0, 16'h1F1F));
        chk_dac("R13 second held-load frame", 16'h0F0F, 16'h7777, 16'h7777, 16'h1F1F);
        ldac_n = 1'b1;
        wait_clk(SETTLE);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(SETTLE);
        t_reset();
        t_write_update();
        t_broadcast_ldac();
        t_short_and_all();
        t_clear_codes();
        t_abort();
        t_code_off();
        t_reserved();
        t_mask();
        t_sync_load();
        finish_run();
    end

endmodule